// File: doc/BRIEF.md
# Fully Associative LRU Page Translation Buffer

This block caches up to four virtual-to-physical page mappings for a system with 32-bit virtual addresses, 20-bit physical addresses and 32 KiB pages. Each address therefore carries a 15-bit page offset. What the buffer handles is a 17-bit virtual page number (VPN) and a 5-bit physical page number (PPN). There are no set-index bits, so the complete VPN is compared against every entry in parallel. On a hit, the stored PPN is returned in the same cycle and no page-table access is needed.

A lookup port reports hit or miss and the PPN for the VPN it is given. A fill port installs a mapping and reports the entry it writes. It also reports whether that write displaced a valid mapping. Each entry keeps a 2-bit recency rank. The four ranks always form a permutation of 0..3. Rank 0 is the most recently used entry and rank 3 is the least recently used. A hit or a fill moves the touched entry to rank 0. Every entry that was more recent than it moves down by one place.

Top module: `xlat_lru_buf`

## Requirements
- R1: After reset, or in the cycle after `flush` is high, every entry is invalid. Lookups then miss, and the next fill writes entry 0 with `fill_evict` low.
- R2: When `lk_valid` is high and a valid entry's tag equals all 17 bits of `lk_vpn`, `lk_hit` is high and `lk_ppn` carries that entry's PPN in the same cycle. Otherwise `lk_hit` is low and `lk_ppn` is zero.
- R3: A fill whose VPN matches no valid entry, while some entry is invalid, writes the lowest-numbered invalid entry. `fill_slot` gives that entry's index (0..3) and `fill_evict` is low.
- R4: A fill whose VPN matches no entry, while all four entries are valid, writes the least recently used entry and drives `fill_evict` high.
- R5: A fill whose VPN is already held rewrites that entry's PPN in place. `fill_slot` names that entry, `fill_evict` is low, and no duplicate tag ever exists.
- R6: A lookup hit makes the hit entry the most recent. The relative order of all other entries is kept.
- R7: A filled entry becomes the most recent. The relative order of all other entries is kept.
- R8: Flush takes priority over any lookup or fill in the same cycle, and it restores the rank order so that entry i has rank i.
- R9: When a lookup and a fill occur in the same cycle, the lookup result reflects the contents before the fill. Only the fill changes the recency order.
- R10: A lookup that misses, or a cycle with no request, leaves the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries and restore the rank order |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 17 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | 5 | PPN on a hit, zero otherwise |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 17 | VPN to install |
| fill_ppn | input | 5 | PPN to install |
| fill_slot | output | 2 | Entry the fill writes (combinational) |
| fill_evict | output | 1 | Fill displaces a valid mapping of another page |

## Verification
Directed sequences fill the buffer in order, touch entries by lookup, and then overflow it. This separates true LRU victim selection from FIFO or fixed-slot replacement. Refilling a VPN that is already present shows in-place update as opposed to duplication. Simultaneous lookup and fill, and flush combined with a request, expose the wrong choice of priority. A long random run uses a small pool of VPNs so that hits, misses, in-place refills and evictions interleave. The reported slot is compared every cycle against a queue of entry indices kept in recency order, which catches any rank update that drifts away from exact LRU.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Recency rank after a touch: the touched entry goes to 0, and entries
  // more recent than the touched one's old rank age by one place.
  function automatic int unsigned next_rank(int unsigned cur,
                                            int unsigned pivot,
                                            bit          is_target);
    if (is_target)
      return 0;
    else if (cur < pivot)
      return cur + 1;
    else
      return cur;
  endfunction

  // Lowest set bit index of a request vector, or 0 when none.
  function automatic int unsigned low_index(logic [31:0] vec, int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = int'(n) - 1; i >= 0; i--)
      if (vec[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N     = 4,
  parameter int KEY_W = 17,
  parameter int DAT_W = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][KEY_W-1:0] tags,
  input  logic [N-1:0][DAT_W-1:0] data,
  input  logic [KEY_W-1:0]        key,
  output logic [N-1:0]            match,
  output logic                    any,
  output logic [IDX_W-1:0]        idx,
  output logic [DAT_W-1:0]        dat
);
  import xlat_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    logic [31:0] wide;
    wide = '0;
    wide[N-1:0] = match;
    any = |match;
    idx = IDX_W'(low_index(wide, N));
    dat = any ? data[idx] : '0;
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][IDX_W-1:0] rank,
  output logic                    free_any,
  output logic [IDX_W-1:0]        free_idx,
  output logic [IDX_W-1:0]        lru_idx
);
  import xlat_pkg::*;

  logic [N-1:0] is_oldest;

  for (genvar g = 0; g < N; g++) begin : g_old
    assign is_oldest[g] = (rank[g] == IDX_W'(N - 1));
  end

  always_comb begin
    logic [31:0] wfree, wold;
    wfree = '0;
    wold  = '0;
    wfree[N-1:0] = ~valid;
    wold[N-1:0]  = is_oldest;
    free_any = |(~valid);
    free_idx = IDX_W'(low_index(wfree, N));
    lru_idx  = IDX_W'(low_index(wold, N));
  end
endmodule

// File: rtl/xlat_lru_buf.sv
module xlat_lru_buf #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 20,
  parameter int PAGE_BITS = 15,
  parameter int ENTRIES   = 4,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic [IDX_W-1:0] fill_slot,
  output logic             fill_evict
);
  import xlat_pkg::*;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q;

  // Named internal events
  logic [ENTRIES-1:0] lm_vec, fm_vec;
  logic               lm_any, fm_any;
  logic [IDX_W-1:0]   lm_idx, fm_idx;
  logic [PPN_W-1:0]   lm_ppn, fm_ppn_unused;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx, lru_idx;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;
  logic [IDX_W-1:0]   pivot;

  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W), .DAT_W(PPN_W)) u_lk_cam (
    .valid(valid_q), .tags(tag_q), .data(ppn_q), .key(lk_vpn),
    .match(lm_vec), .any(lm_any), .idx(lm_idx), .dat(lm_ppn)
  );

  xlat_cam #(.N(ENTRIES), .KEY_W(VPN_W), .DAT_W(PPN_W)) u_fill_cam (
    .valid(valid_q), .tags(tag_q), .data(ppn_q), .key(fill_vpn),
    .match(fm_vec), .any(fm_any), .idx(fm_idx), .dat(fm_ppn_unused)
  );

  xlat_victim #(.N(ENTRIES)) u_victim (
    .valid(valid_q), .rank(rank_q),
    .free_any(free_any), .free_idx(free_idx), .lru_idx(lru_idx)
  );

  always_comb begin
    lk_hit     = lk_valid && lm_any;
    lk_ppn     = lk_hit ? lm_ppn : '0;
    fill_slot  = fm_any ? fm_idx : (free_any ? free_idx : lru_idx);
    fill_evict = fill_valid && !fm_any && !free_any;
    touch_en   = fill_valid || lk_hit;
    touch_idx  = fill_valid ? fill_slot : lm_idx;
    pivot      = rank_q[touch_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++)
        rank_q[i] <= IDX_W'(next_rank(int'(rank_q[i]), int'(pivot),
                                      i == int'(touch_idx)));
      if (fill_valid) valid_q[fill_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && fill_valid) begin
      tag_q[fill_slot] <= fill_vpn;
      ppn_q[fill_slot] <= fill_ppn;
    end
  end
endmodule

// File: rtl/xlat_lru_buf_chk.sv
module xlat_lru_buf_chk #(
  parameter int N     = 4,
  parameter int VPN_W = 17,
  parameter int IDX_W = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic                    lk_valid,
  input logic                    lk_hit,
  input logic                    fill_valid,
  input logic                    fill_evict,
  input logic [N-1:0]            valid_q,
  input logic [N-1:0][VPN_W-1:0] tag_q,
  input logic [N-1:0][IDX_W-1:0] rank_q,
  input logic [N-1:0]            lm_vec
);
  logic perm_ok, dup;

  always_comb begin
    perm_ok = 1'b1;
    dup     = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] hold;
      for (int i = 0; i < N; i++) hold[i] = (rank_q[i] == IDX_W'(k));
      if ($countones(hold) != 1) perm_ok = 1'b0;
    end
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
  end

  assert_rank_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ok);
  assert_no_dup_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);
  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lm_vec));
  assert_evict_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evict |-> (&valid_q));
  assert_idle_keeps_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !fill_valid && !lk_hit) |=> $stable(rank_q));
  assert_hit_keeps_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit && !flush && !fill_valid) |=> $stable(valid_q));
endmodule

bind xlat_lru_buf xlat_lru_buf_chk #(.N(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .fill_valid(fill_valid), .fill_evict(fill_evict), .valid_q(valid_q),
  .tag_q(tag_q), .rank_q(rank_q), .lm_vec(lm_vec)
);

// File: tb/xlat_lru_buf_test.sv
`timescale 1ns/1ps
module xlat_lru_buf_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0;
  logic        lk_valid = 0;
  logic [16:0] lk_vpn = '0;
  logic        lk_hit;
  logic [4:0]  lk_ppn;
  logic        fill_valid = 0;
  logic [16:0] fill_vpn = '0;
  logic [4:0]  fill_ppn = '0;
  logic [1:0]  fill_slot;
  logic        fill_evict;

  int checks = 0;
  int failures = 0;

  // Reference: per-slot contents plus a queue of slot indices, most recent first.
  bit       m_val[4];
  int       m_tag[4];
  int       m_ppn[4];
  int       order[$];

  always #2 clk = ~clk;

  xlat_lru_buf uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_slot(fill_slot), .fill_evict(fill_evict)
  );

  task automatic model_clear();
    order = {};
    for (int i = 0; i < 4; i++) begin
      m_val[i] = 0;
      order.push_back(i);
    end
  endtask

  task automatic model_touch(int s);
    for (int i = 0; i < order.size(); i++)
      if (order[i] == s) begin
        order.delete(i);
        break;
      end
    order.push_front(s);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare, then advance the model at posedge.
  task automatic step(bit fl, bit lv, int lvpn, bit fv, int fvpn, int fppn, string ctx);
    int  e_hit, e_ppn, e_slot, e_ev, fmatch, ffree;
    string freq;
    @(negedge clk);
    flush = fl; lk_valid = lv; lk_vpn = 17'(lvpn);
    fill_valid = fv; fill_vpn = 17'(fvpn); fill_ppn = 5'(fppn);
    #1;
    e_hit = 0; e_ppn = 0; fmatch = -1; ffree = -1;
    for (int i = 0; i < 4; i++) begin
      if (lv && m_val[i] && m_tag[i] == lvpn) begin e_hit = 1; e_ppn = m_ppn[i]; end
      if (m_val[i] && m_tag[i] == fvpn) fmatch = i;
    end
    for (int i = 3; i >= 0; i--) if (!m_val[i]) ffree = i;
    if (fmatch >= 0) begin e_slot = fmatch; e_ev = 0; freq = "R5"; end
    else if (ffree >= 0) begin e_slot = ffree; e_ev = 0; freq = "R3"; end
    else begin e_slot = order[3]; e_ev = 1; freq = "R4"; end
    check({"R2 hit ", ctx}, int'(lk_hit), e_hit);
    check({"R2 ppn ", ctx}, int'(lk_ppn), e_ppn);
    if (fv) begin
      check({freq, " slot ", ctx}, int'(fill_slot), e_slot);
      check({freq, " evict ", ctx}, int'(fill_evict), e_ev);
    end else
      check({"R10 evict idle ", ctx}, int'(fill_evict), 0);
    @(posedge clk);
    if (fl) model_clear();
    else if (fv) begin
      m_val[e_slot] = 1; m_tag[e_slot] = fvpn; m_ppn[e_slot] = fppn;
      model_touch(e_slot);                       // R7
    end else if (e_hit != 0) begin
      for (int i = 0; i < 4; i++)
        if (m_val[i] && m_tag[i] == lvpn) model_touch(i);   // R6
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: empty after reset; lookup misses, first fill goes to entry 0
    step(0, 1, 'h100, 0, 0, 0, "R1 reset lookup");
    step(0, 0, 0, 1, 'h100, 3, "R1 first fill");
    step(0, 0, 0, 1, 'h1ffff, 7, "R3 second fill");
    step(0, 0, 0, 1, 'h00101, 9, "R3 third fill");
    step(0, 0, 0, 1, 'h10100, 11, "R3 fourth fill");
    // R2: full 17-bit compare, near-miss tag differs in top bit only
    step(0, 1, 'h00100, 0, 0, 0, "R2 hit");
    step(0, 1, 'h10101, 0, 0, 0, "R2 near miss");
    // R6: touch entry 1 and 0; victim must then be entry 2
    step(0, 1, 'h1ffff, 0, 0, 0, "R6 touch");
    step(0, 0, 0, 1, 'h2222, 13, "R4 evict after touch R6");
    // R5: refill present tag in place
    step(0, 0, 0, 1, 'h2222, 14, "R5 refill");
    step(0, 1, 'h2222, 0, 0, 0, "R5 new ppn visible");
    // R10: missing lookup does not change order
    step(0, 1, 'h3333, 0, 0, 0, "R10 miss");
    step(0, 0, 0, 1, 'h4444, 15, "R10 victim unchanged R7");
    // R9: lookup and fill together; lookup sees old contents, no touch
    step(0, 1, 'h00100, 1, 'h5555, 16, "R9 simultaneous");
    step(0, 0, 0, 1, 'h6666, 17, "R9 victim after simultaneous");
    // R8: flush beats a fill in the same cycle
    step(1, 1, 'h6666, 1, 'h7777, 18, "R8 flush with fill");
    step(0, 1, 'h7777, 0, 0, 0, "R8 after flush R1");
    step(0, 0, 0, 1, 'h7777, 19, "R8 fill after flush R1");
    // Random mixed traffic over a small VPN pool
    for (int n = 0; n < 4000; n++) begin
      bit fl, lv, fv;
      int a, b;
      fl = ($urandom_range(0, 99) == 0);
      lv = $urandom_range(0, 1) == 1;
      fv = $urandom_range(0, 2) == 0;
      a  = $urandom_range(0, 6) * 'h2345;
      b  = $urandom_range(0, 6) * 'h2345;
      step(fl, lv, a, fv, b, $urandom_range(0, 31), "random R6 R7");
    end
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; flush = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule